// File: doc/BRIEF.md
# Sized Condition Code Generator

This block sits behind an arithmetic unit and turns one operation's outcome into condition flags and a written-back register value. The adder and operand steering stay outside. The block receives four things: the source and destination operands, the raw adder sum, and the carries out of the three size boundaries. It also takes a size code, an operation class and an enable that lets the extend flag follow the carry.

Each flag is evaluated at the most significant bit of the selected size, so a byte operation looks only at bits 7:0. The sized result is merged into the destination value. The destination bits above the size are kept. Flags and the merged value are registered on every cycle in which `op_valid_i` is high, and they hold otherwise.

For subtraction, the external adder is expected to form destination plus inverted source plus one. The carries it reports are the carries of that sum.

Top module: `ccg_top`

## Requirements
- R1: Z (flags_o[2]) is 1 exactly when the result bits within the selected size are all zero.
- R2: N (flags_o[3]) equals result bit 7, 15 or 31 for size code 00 (byte), 01 (word) or 10 (long).
- R3: C (flags_o[0]) is the carry out of the sized most significant bit for class 00 (add). For class 01 (subtract) it is the inverse of that carry, i.e. the borrow. carry_i bit 0, 1 and 2 carry the boundary carries of bits 7, 15 and 31.
- R4: V (flags_o[1]) is set when the destination and the (subtract: inverted) source have equal sized sign bits and the sized result sign differs from them.
- R5: X (flags_o[4]) takes the new C for add or subtract when upd_x_i is 1, and holds its previous value when upd_x_i is 0.
- R6: result_o receives sum bits 7:0, 15:0 or 31:0 per size, and the remaining upper bits come from dst_i.
- R7: For class 10 (logic), V and C are 0 and X holds, whatever carry_i and upd_x_i are.
- R8: While op_valid_i is 0, flags_o and result_o keep their values.
- R9: After reset, flags_o and result_o are all zero.
- R10: Size code 11 behaves as long and class code 11 behaves as logic.
- R11: Outputs reflect an operation on the clock edge at which op_valid_i is sampled high (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Capture this cycle's operation |
| size_i | input | 2 | 00 byte, 01 word, 10/11 long |
| opcls_i | input | 2 | 00 add, 01 subtract, 10/11 logic |
| upd_x_i | input | 1 | Let X follow C for arithmetic classes |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand and merge base |
| sum_i | input | 32 | Raw result from the adder or logic unit |
| carry_i | input | 3 | Carries out of bits 7, 15, 31 |
| flags_o | output | 5 | {X, N, Z, V, C} |
| result_o | output | 32 | Destination with the sized result merged in |

## Verification
The sweep crosses operands at the sign and magnitude edges of every size (0, 1, 0x7F, 0x80, 0xFF, 0x7FFF, 0x8000, 0xFFFF, 0x7FFFFFFF, 0x80000000, all ones), so that carries and overflows occur at one size but not at the others. A design that reads flags at bit 31 for every size would report wrong N, C and V on byte and word results whose upper bits differ. A design that writes the full register on short operations would lose the destination's upper bits. Subtract cases where the destination is smaller than the source catch a C that was not inverted into a borrow. Logic cases are driven with all carries high, which exposes any leak into C, V or X. Idle cycles with changing inputs expose outputs that do not hold.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_ALT  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        OPC_ADD = 2'b00,
        OPC_SUB = 2'b01,
        OPC_LOG = 2'b10,
        OPC_ALT = 2'b11
    } opcls_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/ccg_lane.sv
`timescale 1ns/1ps
// Flag evaluation for one operand width.
module ccg_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] sum_i,
    input  logic         carry_i,
    input  logic         is_sub_i,
    output logic         n_o,
    output logic         z_o,
    output logic         v_o,
    output logic         c_o
);
    logic src_sign_eff;

    always_comb begin
        src_sign_eff = is_sub_i ? ~src_i[W-1] : src_i[W-1];
        n_o = sum_i[W-1];
        z_o = ~|sum_i;
        v_o = (dst_i[W-1] == src_sign_eff) && (sum_i[W-1] != dst_i[W-1]);
        c_o = is_sub_i ? ~carry_i : carry_i;
    end
endmodule

// File: rtl/ccg_merge.sv
`timescale 1ns/1ps
// Replace the low bits of the destination by the sized result.
module ccg_merge #(
    parameter int DW = 32
) (
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] sum_i,
    output logic [DW-1:0] merged_o
);
    import ccg_pkg::*;

    localparam int BW = DW / 4;
    localparam int WW = DW / 2;
    localparam logic [DW-1:0] BYTE_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [DW-1:0] WORD_MASK = {{(DW-WW){1'b0}}, {WW{1'b1}}};

    logic [DW-1:0] keep_mask;

    always_comb begin
        case (size_e'(size_i))
            SZ_BYTE: keep_mask = BYTE_MASK;
            SZ_WORD: keep_mask = WORD_MASK;
            default: keep_mask = '1;
        endcase
        merged_o = (dst_i & ~keep_mask) | (sum_i & keep_mask);
    end
endmodule

// File: rtl/ccg_top.sv
`timescale 1ns/1ps
module ccg_top #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid_i,
    input  logic [1:0]    size_i,
    input  logic [1:0]    opcls_i,
    input  logic          upd_x_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] sum_i,
    input  logic [2:0]    carry_i,
    output logic [4:0]    flags_o,
    output logic [DW-1:0] result_o
);
    import ccg_pkg::*;

    typedef struct packed {
        flags_t        flags;
        logic [DW-1:0] res;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SIZES-1:0] ln_n, ln_z, ln_v, ln_c;
    logic                 is_sub;
    logic [DW-1:0]        merged;

    assign is_sub = (opcls_e'(opcls_i) == OPC_SUB);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = (DW / 4) << g;
        ccg_lane #(.W(LW)) i_lane (
            .src_i    (src_i[LW-1:0]),
            .dst_i    (dst_i[LW-1:0]),
            .sum_i    (sum_i[LW-1:0]),
            .carry_i  (carry_i[g]),
            .is_sub_i (is_sub),
            .n_o      (ln_n[g]),
            .z_o      (ln_z[g]),
            .v_o      (ln_v[g]),
            .c_o      (ln_c[g])
        );
    end

    ccg_merge #(.DW(DW)) i_merge (
        .size_i   (size_i),
        .dst_i    (dst_i),
        .sum_i    (sum_i),
        .merged_o (merged)
    );

    always_comb begin
        int sel;
        state_d = state_q;
        case (size_e'(size_i))
            SZ_BYTE: sel = 0;
            SZ_WORD: sel = 1;
            default: sel = 2;
        endcase
        if (op_valid_i) begin
            state_d.res     = merged;
            state_d.flags.n = ln_n[sel];
            state_d.flags.z = ln_z[sel];
            case (opcls_e'(opcls_i))
                OPC_ADD, OPC_SUB: begin
                    state_d.flags.v = ln_v[sel];
                    state_d.flags.c = ln_c[sel];
                    if (upd_x_i) begin
                        state_d.flags.x = ln_c[sel];
                    end
                end
                default: begin
                    state_d.flags.v = 1'b0;
                    state_d.flags.c = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o  = state_q.flags;
    assign result_o = state_q.res;
endmodule

// File: rtl/ccg_chk.sv
`timescale 1ns/1ps
module ccg_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid_i,
    input logic [1:0]    size_i,
    input logic [1:0]    opcls_i,
    input logic          upd_x_i,
    input logic [DW-1:0] dst_i,
    input logic [DW-1:0] sum_i,
    input logic [4:0]    flags_o,
    input logic [DW-1:0] result_o
);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(flags_o) && $stable(result_o)));

    // R7
    logic_vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && opcls_i[1]) |=> (flags_o[1:0] == 2'b00));

    // R5
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (!upd_x_i || opcls_i[1])) |=> (flags_o[4] == $past(flags_o[4])));

    // R6
    byte_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && size_i == 2'b00) |=> (result_o[DW-1:DW/4] == $past(dst_i[DW-1:DW/4])));

    // R1
    byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && size_i == 2'b00) |=> (flags_o[2] == ($past(sum_i[DW/4-1:0]) == '0)));

    // R2
    long_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && size_i[1]) |=> (flags_o[3] == $past(sum_i[DW-1])));
endmodule

bind ccg_top ccg_chk #(.DW(DW)) i_ccg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .size_i     (size_i),
    .opcls_i    (opcls_i),
    .upd_x_i    (upd_x_i),
    .dst_i      (dst_i),
    .sum_i      (sum_i),
    .flags_o    (flags_o),
    .result_o   (result_o)
);

// File: tb/test_ccg_top.sv
`timescale 1ns/1ps
module test_ccg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [1:0]  opcls_i = '0;
    logic        upd_x_i = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] sum_i = '0;
    logic [2:0]  carry_i = '0;
    logic [4:0]  flags_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic exp_x = 1'b0;

    always #2 clk = ~clk;

    ccg_top #(.DW(32)) i_ccg_top (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .size_i(size_i),
        .opcls_i(opcls_i), .upd_x_i(upd_x_i), .src_i(src_i), .dst_i(dst_i),
        .sum_i(sum_i), .carry_i(carry_i), .flags_o(flags_o), .result_o(result_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input longint v, input int w);
        return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [1:0] oc, input logic ux,
                          input logic [31:0] d, input logic [31:0] s);
        int w;
        longint m, dm, sm, rm, sd, ss, sr;
        logic [31:0] raw, exp_res;
        logic [2:0] cy;
        logic en, ez, ev, ec;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = (longint'(1) << w) - 1;
        dm = longint'(d) & m;
        sm = longint'(s) & m;
        if (oc == 2'b00) begin
            raw = d + s;
            for (int k = 0; k < 3; k++) begin
                longint mk = (longint'(1) << (8 << k)) - 1;
                cy[k] = (((longint'(d) & mk) + (longint'(s) & mk)) >> (8 << k)) != 0;
            end
        end else if (oc == 2'b01) begin
            raw = d + ~s + 32'd1;
            for (int k = 0; k < 3; k++) begin
                longint mk = (longint'(1) << (8 << k)) - 1;
                cy[k] = (((longint'(d) & mk) + (longint'(~s) & mk) + 1) >> (8 << k)) != 0;
            end
        end else begin
            raw = oc[0] ? (d ^ s) : (d & s);
            cy = 3'b111;
        end
        rm = longint'(raw) & m;
        en = rm[w-1];
        ez = (rm == 0);
        if (oc == 2'b00) begin
            ec = (dm + sm) > m;
            sr = sx(dm, w) + sx(sm, w);
        end else if (oc == 2'b01) begin
            ec = sm > dm;
            sr = sx(dm, w) - sx(sm, w);
        end else begin
            ec = 1'b0;
            sr = 0;
        end
        ev = (sr > ((longint'(1) << (w - 1)) - 1)) || (sr < -(longint'(1) << (w - 1)));
        if (!oc[1] && ux) exp_x = ec;
        exp_res = (d & ~32'(m)) | 32'(rm);

        @(negedge clk);
        op_valid_i = 1'b1; size_i = sz; opcls_i = oc; upd_x_i = ux;
        src_i = s; dst_i = d; sum_i = raw; carry_i = cy;
        @(negedge clk);
        op_valid_i = 1'b0;
        // R11: sampled one edge after capture
        chk("R1 zero", 32'(flags_o[2]), 32'(ez));
        chk("R2 sign", 32'(flags_o[3]), 32'(en));
        chk(oc[1] ? "R7 carry clear" : "R3 carry", 32'(flags_o[0]), 32'(ec));
        chk(oc[1] ? "R7 overflow clear" : "R4 overflow", 32'(flags_o[1]), 32'(ev));
        chk(oc[1] ? "R7 extend hold" : "R5 extend", 32'(flags_o[4]), 32'(exp_x));
        chk((sz == 2'b11) ? "R10 size alt merge" : "R6 merge", result_o, exp_res);
    endtask

    initial begin
        logic [31:0] pats [12];
        logic [4:0]  held_f;
        logic [31:0] held_r;
        int n;
        pats = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000,
                 32'hFFFF, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12A5C380};
        repeat (3) @(negedge clk);
        // R9
        chk("R9 reset flags", 32'(flags_o), 32'h0);
        chk("R9 reset result", result_o, 32'h0);
        rst_n = 1'b1;
        n = 0;
        for (int sz = 0; sz < 4; sz++)
            for (int oc = 0; oc < 4; oc++)
                for (int a = 0; a < 12; a++)
                    for (int b = 0; b < 12; b++) begin
                        run_op(2'(sz), 2'(oc), logic'(n % 3 != 0), pats[a], pats[b]);
                        n++;
                    end
        // R8: idle cycles with changing inputs
        run_op(2'b10, 2'b01, 1'b1, 32'h5, 32'h9);
        held_f = flags_o;
        held_r = result_o;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_valid_i = 1'b0; size_i = 2'(k); opcls_i = 2'(k);
            dst_i = 32'hA5A5A5A5 ^ 32'(k); src_i = 32'h3C; sum_i = 32'h0; carry_i = 3'b101;
            upd_x_i = 1'b1;
            @(negedge clk);
            chk("R8 hold flags", 32'(flags_o), 32'(held_f));
            chk("R8 hold result", result_o, held_r);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule